// File: doc/BRIEF.md
# Common Scan Shift Register Driver

This block drives the row (common) side of a dot-matrix LCD. A chain of scan stages takes the frame marker as its serial input and moves it by one stage on every rising edge of the line clock. A direction input decides whether the marker enters at the first stage and travels upward, or enters at the last stage and travels downward. For every stage the block forms a 2-bit code that names one of four drive levels. The code depends on whether that stage holds the marker and on the polarity of the alternation signal. An analog stage outside this block turns each code into a voltage.

The block also handles blanking. In master mode it drives an active-low display-off control line out to its neighbours. That line is held active from reset until the first frame marker has been captured, and after that it follows the local display-off pin. In slave mode the local pin is ignored and the incoming control line from the master blanks the outputs. While blanked, every output carries level V1.

Top module: `comScanDriver`

## Requirements
- R1: While reset is asserted and afterwards, until a line-clock edge samples the frame marker high, master mode holds `dispCtlOut` low (display off) and every output code at V1 (2'b00). Asserting reset again restores this state.
- R2: With `shiftDown` low, a line-clock edge loads `frameIn` into stage 0 and moves stage i into stage i+1. After the marker has passed stage 239, no stage is selected.
- R3: With `shiftDown` high, a line-clock edge loads `frameIn` into stage 239 and moves stage i into stage i-1.
- R4: When not blanked, stage i drives `levelOut[2i+1:2i]` with: selected and `altIn` high gives V1=2'b00; selected and `altIn` low gives V6=2'b11; unselected and `altIn` high gives V5=2'b10; unselected and `altIn` low gives V2=2'b01.
- R5: In master mode, after the marker has been captured, `dispOffN` low forces every output to V1.
- R6: In master mode, after the marker has been captured, `dispCtlOut` equals `dispOffN`, and `dispCtlIn` has no effect.
- R7: In slave mode, `dispCtlIn` low forces every output to V1, `dispOffN` has no effect, and `dispCtlOut` is held high.
- R8: In slave mode with `dispCtlIn` high, the outputs follow the encoding of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lineClk | input | 1 | Line clock; the scan stages advance on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| frameIn | input | 1 | Frame marker; serial input of the scan chain |
| altIn | input | 1 | Alternation polarity |
| shiftDown | input | 1 | 0: entry at stage 0, moving up; 1: entry at stage 239, moving down |
| dispOffN | input | 1 | Local display-off pin, active low (used in master mode only) |
| isMaster | input | 1 | 1: master, 0: slave |
| dispCtlIn | input | 1 | Incoming display-off control from the master, active low |
| dispCtlOut | output | 1 | Outgoing display-off control, active low |
| levelOut | output | 480 | Two-bit level code per stage; stage i at bits [2i+1:2i] |

## Verification
The properties take for granted that `isMaster`, `dispOffN`, `dispCtlIn`, `shiftDown` and `frameIn` change only while the line clock is low, so a single edge samples one stable combination. The entry-stage properties also take for granted that a marker loaded at an edge stays in the entry stage until the next edge. The bench drives every clock pulse itself and changes its inputs only between pulses. Between sequences it applies reset, so each scan pattern starts from a known empty chain.

// File: rtl/comScanPkg.sv
package comScanPkg;
  typedef enum logic [1:0] {
    LVL_V1 = 2'b00,
    LVL_V2 = 2'b01,
    LVL_V5 = 2'b10,
    LVL_V6 = 2'b11
  } levelT;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftUp;   // marker enters stage 0 and moves upward
    logic blankAll;  // force every output to V1
  } scanCtlT;
endpackage

// File: rtl/scanControl.sv
module scanControl
  import comScanPkg::*;
(
  input  logic    lineClk,
  input  logic    rstN,
  input  logic    frameIn,
  input  logic    shiftDown,
  input  logic    dispOffN,
  input  logic    isMaster,
  input  logic    dispCtlIn,
  output scanCtlT ctl,
  output logic    dispCtlOut
);
  logic armed;       // first frame marker seen since reset
  logic masterCtl;

  always_ff @(posedge lineClk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else if (frameIn) armed <= 1'b1;
  end

  assign masterCtl = armed & dispOffN;
  assign dispCtlOut = isMaster ? masterCtl : 1'b1;

  always_comb begin
    ctl.shiftUp  = ~shiftDown;
    ctl.blankAll = isMaster ? ~masterCtl : ~dispCtlIn;
  end
endmodule

// File: rtl/scanDatapath.sv
module scanDatapath
  import comScanPkg::*;
#(
  parameter int NUM_STAGES = 240
) (
  input  logic                      lineClk,
  input  logic                      rstN,
  input  logic                      frameIn,
  input  logic                      altIn,
  input  scanCtlT                   ctl,
  output logic [2*NUM_STAGES-1:0]   levelOut
);
  localparam int LAST = NUM_STAGES - 1;

  logic [LAST:0] stages;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    logic fromBelow, fromAbove, nextBit;
    levelT code;

    if (i == 0) begin : g_low
      assign fromBelow = frameIn;
    end else begin : g_lowMid
      assign fromBelow = stages[i-1];
    end

    if (i == LAST) begin : g_high
      assign fromAbove = frameIn;
    end else begin : g_highMid
      assign fromAbove = stages[i+1];
    end

    assign nextBit = ctl.shiftUp ? fromBelow : fromAbove;

    always_ff @(posedge lineClk or negedge rstN) begin
      if (!rstN) stages[i] <= 1'b0;
      else stages[i] <= nextBit;
    end

    always_comb begin
      if (ctl.blankAll) code = LVL_V1;
      else if (stages[i]) code = altIn ? LVL_V1 : LVL_V6;
      else code = altIn ? LVL_V5 : LVL_V2;
    end

    assign levelOut[2*i +: 2] = code;
  end
endmodule

// File: rtl/comScanDriver.sv
module comScanDriver
  import comScanPkg::*;
#(
  parameter int NUM_STAGES = 240
) (
  input  logic                    lineClk,
  input  logic                    rstN,
  input  logic                    frameIn,
  input  logic                    altIn,
  input  logic                    shiftDown,
  input  logic                    dispOffN,
  input  logic                    isMaster,
  input  logic                    dispCtlIn,
  output logic                    dispCtlOut,
  output logic [2*NUM_STAGES-1:0] levelOut
);
  scanCtlT ctl;

  scanControl u_control (
    .lineClk    (lineClk),
    .rstN       (rstN),
    .frameIn    (frameIn),
    .shiftDown  (shiftDown),
    .dispOffN   (dispOffN),
    .isMaster   (isMaster),
    .dispCtlIn  (dispCtlIn),
    .ctl        (ctl),
    .dispCtlOut (dispCtlOut)
  );

  scanDatapath #(.NUM_STAGES(NUM_STAGES)) u_datapath (
    .lineClk  (lineClk),
    .rstN     (rstN),
    .frameIn  (frameIn),
    .altIn    (altIn),
    .ctl      (ctl),
    .levelOut (levelOut)
  );
endmodule

// File: rtl/comScanChecker.sv
module comScanChecker #(
  parameter int NUM_STAGES = 240
) (
  input logic                    lineClk,
  input logic                    rstN,
  input logic                    frameIn,
  input logic                    shiftDown,
  input logic                    dispOffN,
  input logic                    isMaster,
  input logic                    dispCtlIn,
  input logic                    dispCtlOut,
  input logic [2*NUM_STAGES-1:0] levelOut
);
  localparam int TOPLSB = 2 * (NUM_STAGES - 1);

  AST_ENTRY_UP: assert property (@(posedge lineClk) disable iff (!rstN)
    (!shiftDown && frameIn) |=> (levelOut[1:0] == 2'b00 || levelOut[1:0] == 2'b11)); // R2

  AST_ENTRY_DOWN: assert property (@(posedge lineClk) disable iff (!rstN)
    (shiftDown && frameIn) |=> (levelOut[TOPLSB +: 2] == 2'b00 || levelOut[TOPLSB +: 2] == 2'b11)); // R3

  AST_MASTER_BLANK: assert property (@(posedge lineClk) disable iff (!rstN)
    (isMaster && !dispOffN) |-> (levelOut == '0)); // R5

  AST_CTL_FOLLOWS_PIN: assert property (@(posedge lineClk) disable iff (!rstN)
    (isMaster && dispCtlOut) |-> dispOffN); // R6

  AST_SLAVE_CTL_HIGH: assert property (@(posedge lineClk) disable iff (!rstN)
    !isMaster |-> dispCtlOut); // R7

  AST_SLAVE_BLANK: assert property (@(posedge lineClk) disable iff (!rstN)
    (!isMaster && !dispCtlIn) |-> (levelOut == '0)); // R7

  AST_NO_MARKER_NO_RELEASE: assert property (@(posedge lineClk) disable iff (!rstN)
    (isMaster && $rose(dispCtlOut) && dispOffN && $stable(dispOffN)) |-> $past(frameIn)); // R1
endmodule

bind comScanDriver comScanChecker #(.NUM_STAGES(NUM_STAGES)) u_checker (
  .lineClk    (lineClk),
  .rstN       (rstN),
  .frameIn    (frameIn),
  .shiftDown  (shiftDown),
  .dispOffN   (dispOffN),
  .isMaster   (isMaster),
  .dispCtlIn  (dispCtlIn),
  .dispCtlOut (dispCtlOut),
  .levelOut   (levelOut)
);

// File: tb/test_comScanDriver.sv
`timescale 1ns/1ps
module test_comScanDriver;
  localparam int N = 240;

  logic lineClk = 1'b0;
  logic rstN = 1'b0;
  logic frameIn = 1'b0;
  logic altIn = 1'b0;
  logic shiftDown = 1'b0;
  logic dispOffN = 1'b1;
  logic isMaster = 1'b1;
  logic dispCtlIn = 1'b1;
  logic dispCtlOut;
  logic [2*N-1:0] levelOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  comScanDriver #(.NUM_STAGES(N)) i_comScanDriver (
    .lineClk(lineClk), .rstN(rstN), .frameIn(frameIn), .altIn(altIn),
    .shiftDown(shiftDown), .dispOffN(dispOffN), .isMaster(isMaster),
    .dispCtlIn(dispCtlIn), .dispCtlOut(dispCtlOut), .levelOut(levelOut)
  );

  // {isMaster, dispOffN, dispCtlIn, altIn, expSel[1:0], expUnsel[1:0], expCtlOut}
  localparam logic [8:0] VEC [9] = '{
    9'b1111_00_10_1,
    9'b1110_11_01_1,
    9'b1011_00_00_0,
    9'b1010_00_00_0,
    9'b1100_11_01_1,
    9'b0011_00_10_1,
    9'b0110_11_01_1,
    9'b0101_00_00_1,
    9'b0000_00_00_1
  };

  // one 250 MHz line-clock period
  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      #2 lineClk = 1'b1;
      #2 lineClk = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] codeAt(input int idx);
    return levelOut[2*idx +: 2];
  endfunction

  // index of the single stage coded as V6 with alt low, -1 if none, -2 if several
  function automatic int selIndex();
    int found = -1;
    for (int i = 0; i < N; i++)
      if (codeAt(i) == 2'b11) found = (found == -1) ? i : -2;
    return found;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    frameIn = 1'b0;
    #3 rstN = 1'b1;
    #1;
  endtask

  initial begin : watchdog
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state in master mode
    isMaster = 1'b1; dispOffN = 1'b1; altIn = 1'b0; shiftDown = 1'b0;
    #1;
    check("R1 ctl during reset", dispCtlOut, 0);
    check("R1 blank during reset", (levelOut == '0), 1);
    doReset();
    pulse(3);
    #1;
    check("R1 ctl before marker", dispCtlOut, 0);
    check("R1 blank before marker", (levelOut == '0), 1);

    // R2: upward shift
    frameIn = 1'b1; pulse(1); frameIn = 1'b0; #1;
    check("R1 ctl released after marker", dispCtlOut, 1);
    check("R2 marker at stage 0", selIndex(), 0);
    check("R4 unselected alt low is V2", codeAt(1), 2'b01);
    pulse(5); #1;
    check("R2 marker at stage 5", selIndex(), 5);

    // table walk with stage 5 selected, stage 0 unselected
    foreach (VEC[v]) begin
      string reqTag, ctlTag;
      isMaster  = VEC[v][8];
      dispOffN  = VEC[v][7];
      dispCtlIn = VEC[v][6];
      altIn     = VEC[v][5];
      #1;
      if (VEC[v][8]) begin
        reqTag = VEC[v][7] ? "R4" : "R5";
        ctlTag = "R6";
      end else begin
        reqTag = VEC[v][6] ? "R8" : "R7";
        ctlTag = "R7";
      end
      check({reqTag, " selected stage"}, codeAt(5), VEC[v][4:3]);
      check({reqTag, " unselected stage"}, codeAt(0), VEC[v][2:1]);
      check({ctlTag, " control out"}, dispCtlOut, VEC[v][0]);
    end

    // R2: marker leaves the top end
    isMaster = 1'b1; dispOffN = 1'b1; dispCtlIn = 1'b1; altIn = 1'b0;
    pulse(N - 6); #1;
    check("R2 marker at stage 239", selIndex(), N - 1);
    pulse(1); #1;
    check("R2 chain empty after top", selIndex(), -1);

    // R1: reset again blanks until a new marker
    doReset();
    check("R1 ctl after second reset", dispCtlOut, 0);
    check("R1 blank after second reset", (levelOut == '0), 1);

    // R3: downward shift
    shiftDown = 1'b1;
    frameIn = 1'b1; pulse(1); frameIn = 1'b0; #1;
    check("R3 marker at stage 239", selIndex(), N - 1);
    pulse(3); #1;
    check("R3 marker at stage 236", selIndex(), N - 4);
    altIn = 1'b1; #1;
    check("R4 selected alt high is V1", codeAt(N - 4), 2'b00);
    check("R4 unselected alt high is V5", codeAt(N - 1), 2'b10);
    altIn = 1'b0;
    pulse(N - 4); #1;
    check("R3 marker at stage 0", selIndex(), 0);
    pulse(1); #1;
    check("R3 chain empty after bottom", selIndex(), -1);

    // R7: in slave mode, a marker-free reset does not blank, pin is ignored
    doReset();
    isMaster = 1'b0; dispOffN = 1'b0; dispCtlIn = 1'b1; #1;
    check("R7 slave ctl high after reset", dispCtlOut, 1);
    check("R8 slave unblanked codes V2", codeAt(10), 2'b01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule